// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block turns a bank of GPIO input lines into a small number of interrupt requests. The lines arrive already polarity-corrected, so a high bit always means "active". Each line has two request paths. The level path passes the live input through a level-enable mask. The edge path catches each 0-to-1 transition in a sticky cause bit, which passes through an edge-enable mask. The two paths are ORed per line. The lines are then ORed in groups of eight, giving one registered summary interrupt per group.

Software reaches three registers through a simple word port. Two enable masks can be written and read. The cause register can be read, and a write to it clears every bit written as zero. Falling-edge detection is obtained outside this block by inverting the line's polarity. The clear write and a new edge can meet in the same cycle, and the new edge takes precedence.

Top module: `gpio_irq_aggr`

## Requirements
- R1: A 0-to-1 transition on `data_in` bit i sets cause bit i at the next clock edge, whatever the masks hold. A 1-to-0 transition sets nothing.
- R2: A cause bit that is set stays set until software clears it. A line that is held high does not set it again.
- R3: A write to offset 0x14 clears each cause bit whose `wr_data` bit is 0 and leaves bits written as 1 unchanged. Writing all zeros clears every cause bit.
- R4: When a rising edge on line i and a clearing write to bit i occur in the same cycle, cause bit i ends up set.
- R5: The level request of line i is `data_in[i]` AND level-enable bit i, with no storage. The request falls as soon as the input falls.
- R6: The edge request of line i is cause bit i AND edge-enable bit i. The line request is the OR of the edge request and the level request.
- R7: `irq[g]` is the OR of the line requests of lines 8g to 8g+7.
- R8: Reset clears the cause register, both enable masks, `irq` and `rd_data`. A line that is high during reset and stays high does not set a cause bit after reset.
- R9: The edge-enable register sits at offset 0x18 and the level-enable register at 0x1C. Both can be written and read back. The cause register is read at 0x14. `rd_data` is registered and shows the register selected by `addr` one cycle after `addr` is presented. Any other address reads 0, and writes to it change nothing.
- R10: `irq` is registered. It follows a change of line request one clock later. A level input therefore reaches `irq` one clock after it changes, and an edge reaches `irq` two clocks after it occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | NUM_LINES (32) | Polarity-corrected line levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register byte offset for reads and writes |
| wr_data | input | NUM_LINES (32) | Write data |
| rd_data | output | NUM_LINES (32) | Registered read data |
| irq | output | NUM_LINES/GROUP (4) | Registered group interrupt summaries |

## Verification
The assertions assume that `data_in` is synchronous to `clk` and that reset is held for at least two clocks. Under that assumption the masks and the cause register are zero before the first cycle the checks look at, and the group outputs can be related to the previous cycle's requests. The stimulus changes inputs only on the falling clock edge and holds reset for three cycles. A line that is high during reset stays high after release, so the no-spurious-cause rule is exercised without breaking these assumptions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFF_CAUSE = 8'h14;
  localparam logic [7:0] OFF_EMASK = 8'h18;
  localparam logic [7:0] OFF_LMASK = 8'h1C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EMASK = 2'd2,
    SEL_LMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cause_latch.sv
module gpio_cause_latch #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] data_in,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_data,
  output logic [NUM_LINES-1:0] cause
);
  logic [NUM_LINES-1:0] din_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] keep;

  // During reset the history tracks the input, so a line held high never looks like an edge.
  assign rise = data_in & ~din_q;
  assign keep = clr_we ? clr_data : {NUM_LINES{1'b1}};

  always_ff @(posedge clk) begin
    din_q <= data_in;
    if (rst) cause <= '0;
    else     cause <= (cause & keep) | rise;
  end

  // R2: without a clearing write no cause bit drops
  assert_cause_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((cause & $past(cause)) == $past(cause)));

  // R1 / R4: a detected edge is present in the cause register one cycle later, even against a clear
  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 emask_we,
  input  logic                 lmask_we,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] edge_mask,
  output logic [NUM_LINES-1:0] level_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_mask  <= '0;
      level_mask <= '0;
    end else begin
      if (emask_we) edge_mask  <= wr_data;
      if (lmask_we) level_mask <= wr_data;
    end
  end

  // R8: masks come out of reset fully closed
  assert_mask_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (edge_mask == '0 && level_mask == '0));

  // R9: a mask only moves on its own write strobe
  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!emask_we && !lmask_we) |=> ($stable(edge_mask) && $stable(level_mask)));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int NUM_LINES = 32,
  parameter int GROUP     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LINES-1:0]         req,
  output logic [NUM_LINES/GROUP-1:0]   irq
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= |req[g*GROUP +: GROUP];
    end

    // R7 / R10: each summary reflects its own eight lines one cycle later
    assert_group_or_R7: assert property (@(posedge clk) disable iff (rst)
      irq[g] == $past(|req[g*GROUP +: GROUP]));
  end
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int GROUP     = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       data_in,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_LINES-1:0]       wr_data,
  output logic [NUM_LINES-1:0]       rd_data,
  output logic [NUM_LINES/GROUP-1:0] irq
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP;

  reg_sel_e             sel;
  logic [NUM_LINES-1:0] cause;
  logic [NUM_LINES-1:0] edge_mask;
  logic [NUM_LINES-1:0] level_mask;
  logic [NUM_LINES-1:0] req;
  logic [NUM_LINES-1:0] rd_mux;

  always_comb begin
    if      (addr == ADDR_W'(OFF_CAUSE)) sel = SEL_CAUSE;
    else if (addr == ADDR_W'(OFF_EMASK)) sel = SEL_EMASK;
    else if (addr == ADDR_W'(OFF_LMASK)) sel = SEL_LMASK;
    else                                 sel = SEL_NONE;
  end

  gpio_cause_latch #(.NUM_LINES(NUM_LINES)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .clr_we   (wr_en && sel == SEL_CAUSE),
    .clr_data (wr_data),
    .cause    (cause)
  );

  gpio_mask_regs #(.NUM_LINES(NUM_LINES)) u_masks (
    .clk        (clk),
    .rst        (rst),
    .emask_we   (wr_en && sel == SEL_EMASK),
    .lmask_we   (wr_en && sel == SEL_LMASK),
    .wr_data    (wr_data),
    .edge_mask  (edge_mask),
    .level_mask (level_mask)
  );

  assign req = (data_in & level_mask) | (cause & edge_mask);

  gpio_group_or #(.NUM_LINES(NUM_LINES), .GROUP(GROUP)) u_groups (
    .clk (clk),
    .rst (rst),
    .req (req),
    .irq (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rd_mux = cause;
      SEL_EMASK: rd_mux = edge_mask;
      SEL_LMASK: rd_mux = level_mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R6: with both masks closed no summary can be raised on the next cycle
  assert_all_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_mask == '0 && level_mask == '0) |=> (irq == '0));

  // R5: a level-enabled line that is high forces its group on the next cycle
  assert_level_pass_R5: assert property (@(posedge clk) disable iff (rst)
    ((data_in & level_mask) != '0) |=> (irq != '0));

  initial assert (NUM_GROUPS * GROUP == NUM_LINES)
    else $error("NUM_LINES must be a multiple of GROUP");
endmodule

// File: tb/test_gpio_irq_aggr.sv
module test_gpio_irq_aggr;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] data_in;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_aggr i_gpio_irq_aggr (
    .clk(clk), .rst(rst), .data_in(data_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    tick();
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R8 irq after reset", {28'd0, irq}, 32'd0);
    rd(8'h14, v); chk("R8 cause clear, held-high line not latched", v, 32'd0);
    rd(8'h18, v); chk("R8 edge mask reset", v, 32'd0);
    rd(8'h1C, v); chk("R8 level mask reset", v, 32'd0);
  endtask

  task automatic t_edge_latch();
    logic [31:0] v;
    data_in[3] = 1'b1;
    tick();
    rd(8'h14, v); chk("R1 rising edge latched while masked", v, 32'h0000_0008);
    chk("R6 masked cause gives no irq", {28'd0, irq}, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    data_in[9] = 1'b1;
    tick();
    wr(8'h14, 32'hFFFF_FFF7);
    rd(8'h14, v); chk("R3 zero bit cleared, one bits kept", v, 32'h0000_0200);
    tick(); tick();
    rd(8'h14, v); chk("R2 held-high line not re-latched", v, 32'h0000_0200);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R3 all-zero write clears all", v, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    data_in[1] = 1'b1;
    tick();
    data_in[2] = 1'b1;
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R4 edge beats same-cycle clear", v, 32'h0000_0004);
    wr(8'h14, 32'h0);
    data_in = 32'h0;
    tick(); tick();
    rd(8'h14, v); chk("R1 falling edges set nothing", v, 32'h0);
  endtask

  task automatic t_level();
    wr(8'h1C, 32'h0000_1000);
    data_in[12] = 1'b1;
    tick();
    chk("R5 R10 level request one clock later", {28'd0, irq}, 32'h2);
    data_in[12] = 1'b0;
    tick();
    chk("R5 level request not held", {28'd0, irq}, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_groups();
    wr(8'h1C, 32'h8080_8080);
    for (int g = 0; g < 4; g++) begin
      data_in = 32'h1 << (g * 8 + 7);
      tick();
      chk("R7 line maps to its group", {28'd0, irq}, 32'h1 << g);
    end
    data_in = 32'h0;
    tick();
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'h0);
    tick();
    chk("R7 all groups idle", {28'd0, irq}, 32'h0);
  endtask

  task automatic t_edge_irq();
    wr(8'h18, 32'h0010_0000);
    data_in[20] = 1'b1;
    tick();
    chk("R10 edge irq not yet visible", {28'd0, irq}, 32'h0);
    tick();
    chk("R6 R10 edge irq after two clocks", {28'd0, irq}, 32'h4);
    data_in[20] = 1'b0;
    tick(); tick();
    chk("R6 edge irq held after input falls", {28'd0, irq}, 32'h4);
    wr(8'h14, 32'h0);
    chk("R10 irq lags the clear by one clock", {28'd0, irq}, 32'h4);
    tick();
    chk("R3 cleared cause drops irq", {28'd0, irq}, 32'h0);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(8'h18, 32'hA5A5_0001);
    rd(8'h18, v); chk("R9 edge mask readback", v, 32'hA5A5_0001);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, v); chk("R9 level mask readback", v, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R9 unmapped address reads zero", v, 32'h0);
    rd(8'h18, v); chk("R9 unmapped write leaves edge mask", v, 32'hA5A5_0001);
    rd(8'h1C, v); chk("R9 unmapped write leaves level mask", v, 32'h1234_5678);
    chk("R9 no irq with inputs low", {28'd0, irq}, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = 8'h0; wr_data = 32'h0;
    data_in = 32'h0000_0020;
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_edge_latch();
    t_clear();
    t_race();
    t_level();
    t_groups();
    t_edge_irq();
    t_regmap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule